// File: doc/BRIEF.md
# Instruction-Phased Dataset Line Prefetch Sequencer

This block sits beside a virtual machine's instruction pipeline and schedules cache-line traffic into a large dataset memory. It counts every retired instruction in a repeating window of 64. At fixed points in that window it issues a prefetch hint for the current line address. It also folds register values from the machine into the address, and later issues the read that brings the line back. The returned 512-bit line is passed on to the machine. If the machine reaches the instruction that consumes the line before the line has arrived, the block holds the machine with a stall output.

There are two scheduling modes. In split mode, the prefetch goes out at the start of the window. The address then absorbs fourteen register values, and the read of the mixed address goes out at phase 14. In joint mode, a single step at the start of the window sends the read of the current line and then the prefetch of the following line, whose address is computed in that same step. A change of mode and a reload of the address from a seed both wait for a window boundary. This keeps every window internally consistent.

Top module: `dsline_prefetch_seq`

## Requirements
- R1: After reset, no request is offered, the stall output is low, no line is returned and the phase is 0. Each retire accepted while stall is low advances the phase by one, modulo 64.
- R2: In split mode (mode 0), an accepted retire at phase 0 queues a prefetch request (type bit 0) for the current address. The address used is the one held before that retire's mixing.
- R3: In split mode, an accepted retire at phases 0 through 13 replaces the address with (address XOR low 32 bits of the mix value), with bits 5:0 cleared. From phase 14 onward the address does not change.
- R4: In split mode, an accepted retire at phase 14 queues a read request (type bit 1) for the mixed address.
- R5: In joint mode (mode 1), an accepted retire at phase 0 queues a read of the current address followed by a prefetch of (address XOR mix) with bits 5:0 cleared. That value becomes the new address, and no mixing happens at any other phase.
- R6: A request that is offered and not accepted keeps its address and type unchanged until accepted. Every requested address has bits 5:0 equal to zero.
- R7: A response that arrives while a read is outstanding appears on the line output, with the same data, one cycle later. A response that arrives with no read outstanding is ignored.
- R8: Stall is high in two cases. The first is at the consuming phase (15 in split mode, 1 in joint mode) while a read is outstanding. The second is at a phase that issues requests while an earlier request is still waiting on the channel.
- R9: A retire presented while stall is high has no effect on the phase, the address or the requests.
- R10: The mode input is sampled only by the accepted retire at phase 63, and it governs the next window.
- R11: A restart pulse captures a seed. The accepted retire at phase 63 that follows loads the address with the seed, bits 5:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retired this cycle |
| mix_val_i | input | 32 | Low bits of the register value mixed into the address |
| mode_i | input | 1 | Requested mode, 0 split, 1 joint |
| restart_i | input | 1 | Request to reload the address at the next boundary |
| seed_i | input | 32 | Address seed captured with restart_i |
| stall_o | output | 1 | Machine must hold its retire |
| req_valid_o | output | 1 | Request offered |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 32 | Line-aligned byte address |
| req_is_read_o | output | 1 | 1 read, 0 prefetch |
| rsp_valid_i | input | 1 | Read data returned |
| rsp_data_i | input | 512 | Returned line |
| line_valid_o | output | 1 | Line delivered to the machine |
| line_data_o | output | 512 | Delivered line |

## Verification
The hardest state to reach is a retire that lands on the consuming phase while the read is still in flight. It only happens when the memory latency exceeds the one-instruction gap to that phase. Reaching it also needs a request that waits on the channel long enough to meet the next issuing phase. The stimulus holds read responses back for many cycles and withholds request acceptance at random, while the machine keeps retiring every cycle. The stall output is compared against a model each cycle, and retires presented during stall must leave the request stream unchanged. Mode switches and seeded restarts are placed in the middle of windows, so that only the boundary rule explains the requests that follow.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic {KIND_PF = 1'b0, KIND_RD = 1'b1} req_kind_e;
  typedef enum logic {MODE_SPLIT = 1'b0, MODE_JOINT = 1'b1} seq_mode_e;
endpackage

// File: rtl/dps_phase.sv
module dps_phase #(
  parameter int WIN    = 64,
  parameter int PH_W   = 6,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_i,
  input  logic                mode_i,
  input  logic                restart_i,
  input  logic [ADDR_W-1:0]   seed_i,
  output logic [PH_W-1:0]     ph_o,
  output dps_pkg::seq_mode_e  mode_o,
  output logic                wrap_o,
  output logic                reload_o,
  output logic [ADDR_W-1:0]   seed_o
);
  import dps_pkg::*;

  logic [PH_W-1:0]   ph_q, ph_d;
  seq_mode_e         mode_q, mode_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] seed_q, seed_d;
  logic              wrap;

  assign wrap = adv_i && (ph_q == PH_W'(WIN - 1));

  always_comb begin
    ph_d   = ph_q;
    mode_d = mode_q;
    pend_d = pend_q;
    seed_d = seed_q;
    if (adv_i) ph_d = ph_q + 1'b1;
    if (wrap) begin
      mode_d = seq_mode_e'(mode_i);
      pend_d = 1'b0;
    end
    if (restart_i) begin
      pend_d = 1'b1;
      seed_d = seed_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      mode_q <= MODE_SPLIT;
      pend_q <= 1'b0;
      seed_q <= '0;
    end else begin
      ph_q   <= ph_d;
      mode_q <= mode_d;
      pend_q <= pend_d;
      seed_q <= seed_d;
    end
  end

  assign ph_o     = ph_q;
  assign mode_o   = mode_q;
  assign wrap_o   = wrap;
  assign reload_o = wrap && pend_q;
  assign seed_o   = seed_q;
endmodule

// File: rtl/dps_addr.sv
module dps_addr #(
  parameter int ADDR_W  = 32,
  parameter int PH_W    = 6,
  parameter int OFF_W   = 6,
  parameter int READ_PH = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_i,
  input  logic [PH_W-1:0]     ph_i,
  input  dps_pkg::seq_mode_e  mode_i,
  input  logic [ADDR_W-1:0]   mix_i,
  input  logic                reload_i,
  input  logic [ADDR_W-1:0]   seed_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [ADDR_W-1:0]   mixed_o
);
  import dps_pkg::*;

  localparam logic [ADDR_W-1:0] LINE_MASK = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  logic [ADDR_W-1:0] addr_q, addr_d, mixed;
  logic              mix_en;

  assign mixed = (addr_q ^ mix_i) & LINE_MASK;

  always_comb begin
    if (mode_i == MODE_SPLIT) mix_en = (ph_i < PH_W'(READ_PH));
    else                      mix_en = (ph_i == '0);
  end

  always_comb begin
    addr_d = addr_q;
    if (adv_i) begin
      if (reload_i)    addr_d = seed_i & LINE_MASK;
      else if (mix_en) addr_d = mixed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o  = addr_q;
  assign mixed_o = mixed;
endmodule

// File: rtl/dps_reqq.sv
module dps_reqq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        push_n_i,
  input  logic              e0_kind_i,
  input  logic [ADDR_W-1:0] e0_addr_i,
  input  logic              e1_kind_i,
  input  logic [ADDR_W-1:0] e1_addr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              empty_o
);
  localparam int EW = ADDR_W + 1;
  localparam int DEPTH = 2;

  logic [EW-1:0] slot_q [DEPTH];
  logic [EW-1:0] slot_d [DEPTH];
  logic [1:0]    cnt_q, cnt_d;
  logic          pop;

  assign pop = (cnt_q != 2'd0) && ready_i;

  always_comb begin
    cnt_d     = cnt_q;
    slot_d[0] = slot_q[0];
    slot_d[1] = slot_q[1];
    if (pop) begin
      slot_d[0] = slot_q[1];
      cnt_d     = cnt_q - 2'd1;
    end
    if (push_n_i == 2'd2) begin
      slot_d[0] = {e0_kind_i, e0_addr_i};
      slot_d[1] = {e1_kind_i, e1_addr_i};
      cnt_d     = 2'd2;
    end else if (push_n_i == 2'd1) begin
      if (cnt_d == 2'd0) slot_d[0] = {e0_kind_i, e0_addr_i};
      else               slot_d[1] = {e0_kind_i, e0_addr_i};
      cnt_d = cnt_d + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign valid_o = (cnt_q != 2'd0);
  assign empty_o = (cnt_q == 2'd0);
  assign kind_o  = slot_q[0][EW-1];
  assign addr_o  = slot_q[0][ADDR_W-1:0];
endmodule

// File: rtl/dps_line.sv
module dps_line #(
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue_i,
  input  logic              rsp_valid_i,
  input  logic [LINE_W-1:0] rsp_data_i,
  output logic              rd_out_o,
  output logic              line_valid_o,
  output logic [LINE_W-1:0] line_data_o
);
  logic              out_q, out_d;
  logic              lv_q, lv_d;
  logic [LINE_W-1:0] ld_q;
  logic              take;

  assign take = rsp_valid_i && out_q;

  always_comb begin
    out_d = out_q;
    if (take)       out_d = 1'b0;
    if (rd_issue_i) out_d = 1'b1;
    lv_d = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      lv_q  <= 1'b0;
      ld_q  <= '0;
    end else begin
      out_q <= out_d;
      lv_q  <= lv_d;
      if (take) ld_q <= rsp_data_i;
    end
  end

  assign rd_out_o     = out_q;
  assign line_valid_o = lv_q;
  assign line_data_o  = ld_q;
endmodule

// File: rtl/dsline_prefetch_seq.sv
module dsline_prefetch_seq #(
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 512,
  parameter int WIN     = 64,
  parameter int READ_PH = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic [ADDR_W-1:0] mix_val_i,
  input  logic              mode_i,
  input  logic              restart_i,
  input  logic [ADDR_W-1:0] seed_i,
  output logic              stall_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_is_read_o,
  input  logic              rsp_valid_i,
  input  logic [LINE_W-1:0] rsp_data_i,
  output logic              line_valid_o,
  output logic [LINE_W-1:0] line_data_o
);
  import dps_pkg::*;

  localparam int PH_W      = $clog2(WIN);
  localparam int OFF_W     = $clog2(LINE_W / 8);
  localparam int USE_SPLIT = READ_PH + 1;

  logic [PH_W-1:0]   ph_q;
  seq_mode_e         mode_q;
  logic              wrap, reload;
  logic [ADDR_W-1:0] seed_q, addr_q, mixed;
  logic              q_empty, rd_out, adv;
  logic              is_split, at0, at_rd, at_use, req_ph;
  logic [1:0]        push_n;
  logic              e0_kind, e1_kind, rd_issue;
  logic [ADDR_W-1:0] e0_addr, e1_addr;

  dps_phase #(.WIN(WIN), .PH_W(PH_W), .ADDR_W(ADDR_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .mode_i(mode_i),
    .restart_i(restart_i), .seed_i(seed_i), .ph_o(ph_q), .mode_o(mode_q),
    .wrap_o(wrap), .reload_o(reload), .seed_o(seed_q)
  );

  dps_addr #(.ADDR_W(ADDR_W), .PH_W(PH_W), .OFF_W(OFF_W), .READ_PH(READ_PH)) u_addr (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .ph_i(ph_q), .mode_i(mode_q),
    .mix_i(mix_val_i), .reload_i(reload), .seed_i(seed_q),
    .addr_o(addr_q), .mixed_o(mixed)
  );

  dps_reqq #(.ADDR_W(ADDR_W)) u_reqq (
    .clk(clk), .rst_n(rst_n), .push_n_i(push_n),
    .e0_kind_i(e0_kind), .e0_addr_i(e0_addr),
    .e1_kind_i(e1_kind), .e1_addr_i(e1_addr),
    .ready_i(req_ready_i), .valid_o(req_valid_o), .kind_o(req_is_read_o),
    .addr_o(req_addr_o), .empty_o(q_empty)
  );

  dps_line #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .rd_issue_i(rd_issue), .rsp_valid_i(rsp_valid_i),
    .rsp_data_i(rsp_data_i), .rd_out_o(rd_out),
    .line_valid_o(line_valid_o), .line_data_o(line_data_o)
  );

  // Phase decode
  assign is_split = (mode_q == MODE_SPLIT);
  assign at0      = (ph_q == '0);
  assign at_rd    = (ph_q == PH_W'(READ_PH));
  assign at_use   = is_split ? (ph_q == PH_W'(USE_SPLIT)) : (ph_q == PH_W'(1));
  assign req_ph   = at0 || (is_split && at_rd);

  assign stall_o = (req_ph && !q_empty) || (at_use && rd_out);
  assign adv     = retire_i && !stall_o;

  always_comb begin
    push_n   = 2'd0;
    e0_kind  = KIND_PF;
    e0_addr  = addr_q;
    e1_kind  = KIND_PF;
    e1_addr  = mixed;
    rd_issue = 1'b0;
    if (adv) begin
      if (is_split) begin
        if (at0) begin
          push_n = 2'd1;
        end else if (at_rd) begin
          push_n   = 2'd1;
          e0_kind  = KIND_RD;
          rd_issue = 1'b1;
        end
      end else if (at0) begin
        push_n   = 2'd2;
        e0_kind  = KIND_RD;
        rd_issue = 1'b1;
      end
    end
  end

  logic unused_wrap;
  assign unused_wrap = wrap;
endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
  parameter int PH_W   = 6,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              retire_i,
  input logic              stall_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              req_is_read_o,
  input logic              rsp_valid_i,
  input logic              line_valid_o,
  input logic [PH_W-1:0]   ph_q
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_is_read_o));

  // R6
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_addr_o[OFF_W-1:0] == '0));

  // R7
  line_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid_o |-> $past(rsp_valid_i));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> $stable(ph_q));

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i && !stall_o |=> (ph_q == PH_W'($past(ph_q) + 1'b1)));
endmodule

bind dsline_prefetch_seq dps_chk #(.PH_W(PH_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .stall_o(stall_o),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
  .req_is_read_o(req_is_read_o), .rsp_valid_i(rsp_valid_i),
  .line_valid_o(line_valid_o), .ph_q(ph_q)
);

// File: tb/dsline_prefetch_seq_tb.sv
`timescale 1ns/1ps
module dsline_prefetch_seq_tb;
  logic         clk, rst_n, retire_i, mode_i, restart_i, req_ready_i, rsp_valid_i;
  logic [31:0]  mix_val_i, seed_i;
  logic         stall_o, req_valid_o, req_is_read_o, line_valid_o;
  logic [31:0]  req_addr_o;
  logic [511:0] rsp_data_i, line_data_o;

  dsline_prefetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .mix_val_i(mix_val_i),
    .mode_i(mode_i), .restart_i(restart_i), .seed_i(seed_i), .stall_o(stall_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .req_is_read_o(req_is_read_o), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .line_valid_o(line_valid_o), .line_data_o(line_data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // scoreboard: expected requests {type, addr} with requirement tag
  logic [32:0]  exp_q[$];
  string        tag_q[$];
  int           m_ph = 0;
  logic [31:0]  m_addr = '0;
  logic         m_mode = 1'b0, m_mode_in = 1'b0, m_pend = 1'b0, m_rd_out = 1'b0;
  logic [31:0]  m_seed = '0;
  int           rsp_cnt = -1;
  logic [31:0]  rsp_addr = '0;
  int           rsp_delay = 2;
  bit           line_due = 0, spur_req = 0, spur_chk = 0;
  logic [511:0] line_exp = '0;

  function automatic logic [31:0] lmask(input logic [31:0] a);
    return a & 32'hFFFF_FFC0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic k, input logic [31:0] a, input string t);
    exp_q.push_back({k, a});
    tag_q.push_back(t);
  endtask

  task automatic model_retire(input logic [31:0] mix);
    logic [31:0] nxt;
    if (m_mode == 1'b0) begin
      if (m_ph == 0) push_exp(1'b0, m_addr, "R2");
      if (m_ph == 14) begin push_exp(1'b1, m_addr, "R3,R4"); m_rd_out = 1'b1; end
      if (m_ph < 14) m_addr = lmask(m_addr ^ mix);
    end else if (m_ph == 0) begin
      nxt = lmask(m_addr ^ mix);
      push_exp(1'b1, m_addr, "R5");
      push_exp(1'b0, nxt, "R5");
      m_addr = nxt;
      m_rd_out = 1'b1;
    end
    if (m_ph == 63) begin
      m_mode = m_mode_in;            // R10
      if (m_pend) begin m_addr = lmask(m_seed); m_pend = 1'b0; end  // R11
    end
    m_ph = (m_ph + 1) % 64;          // R1
  endtask

  task automatic step(input bit want, input bit ready);
    bit req_ph, use_ph, exp_stall;
    logic [32:0] e;
    string t;
    logic [31:0] mix;
    @(negedge clk);
    restart_i = 1'b0;
    // line output monitor (R7)
    if (spur_chk) begin
      chk(line_valid_o == 1'b0, "R7", "ignored response", {63'd0, line_valid_o}, 64'd0);
      spur_chk = 0;
    end else if (line_due || line_valid_o) begin
      chk(line_valid_o && line_data_o == line_exp, "R7", "line return",
          line_data_o[63:0], line_exp[63:0]);
    end
    line_due = 0;
    // stall monitor (R8, R9)
    req_ph = (m_ph == 0) || (m_mode == 1'b0 && m_ph == 14);
    use_ph = (m_mode == 1'b0) ? (m_ph == 15) : (m_ph == 1);
    exp_stall = (req_ph && exp_q.size() != 0) || (use_ph && m_rd_out);
    chk(stall_o == exp_stall, "R8", "stall", {63'd0, stall_o}, {63'd0, exp_stall});
    chk(req_valid_o == (exp_q.size() != 0), "R6", "req valid",
        {63'd0, req_valid_o}, {63'd0, exp_q.size() != 0});
    // responses
    rsp_valid_i = 1'b0;
    if (rsp_cnt == 0) begin
      rsp_valid_i = 1'b1;
      rsp_data_i  = {16{rsp_addr}};
      line_exp    = {16{rsp_addr}};
      line_due    = 1;
      m_rd_out    = 1'b0;
      rsp_cnt     = -1;
    end else if (rsp_cnt > 0) begin
      rsp_cnt--;
    end else if (spur_req && !m_rd_out) begin
      rsp_valid_i = 1'b1;
      rsp_data_i  = {512{1'b1}};
      spur_req = 0;
      spur_chk = 1;
    end
    // request handshake
    req_ready_i = ready;
    if (req_valid_o && ready && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({req_is_read_o, req_addr_o} == e, t, "request",
          {31'd0, req_is_read_o, req_addr_o}, {31'd0, e});
      if (req_is_read_o) begin rsp_cnt = rsp_delay; rsp_addr = req_addr_o; end
    end
    // retire
    mix = $urandom;
    mix_val_i = mix;
    retire_i  = want;
    if (want && !stall_o) model_retire(mix);  // retire under stall ignored: R9
  endtask

  task automatic run(input int n, input bit rnd_ready);
    for (int i = 0; i < n; i++) step(1'b1, rnd_ready ? ($urandom % 3 != 0) : 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; retire_i = 0; mode_i = 0; restart_i = 0; req_ready_i = 0;
    rsp_valid_i = 0; mix_val_i = '0; seed_i = '0; rsp_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_valid_o == 1'b0, "R1", "reset req_valid", {63'd0, req_valid_o}, 64'd0);
    chk(stall_o == 1'b0, "R1", "reset stall", {63'd0, stall_o}, 64'd0);
    chk(line_valid_o == 1'b0, "R1", "reset line_valid", {63'd0, line_valid_o}, 64'd0);
    // split mode, quick memory
    rsp_delay = 2;  run(200, 1'b0);
    // split mode, slow memory and back-pressure: stalls at the consuming phase
    rsp_delay = 25; run(300, 1'b1);
    // request joint mode mid-window; takes effect at boundary (R10)
    mode_i = 1'b1; m_mode_in = 1'b1;
    rsp_delay = 5;  run(250, 1'b1);
    // restart with seed mid-window (R11)
    step(1'b0, 1'b1);
    @(negedge clk);
    restart_i = 1'b1; seed_i = 32'hDEAD_BEEF;
    m_pend = 1'b1; m_seed = 32'hDEAD_BEEF;
    retire_i = 1'b0; req_ready_i = 1'b0; rsp_valid_i = 1'b0;
    if (rsp_cnt > 0) rsp_cnt--;
    run(150, 1'b0);
    // back to split mode
    mode_i = 1'b0; m_mode_in = 1'b0;
    rsp_delay = 0; run(150, 1'b1);
    // spurious response with nothing outstanding (R7)
    for (int i = 0; i < 200 && (m_rd_out || rsp_cnt >= 0); i++) step(1'b0, 1'b1);
    spur_req = 1;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    // drain
    for (int i = 0; i < 200 && (exp_q.size() != 0 || rsp_cnt >= 0 || line_due); i++)
      step(1'b0, 1'b1);
    chk(exp_q.size() == 0, "R6", "all requests seen", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule